// File: doc/BRIEF.md
# Single-Error-Correct Double-Error-Detect Byte Codec

This block protects one byte with a 13-bit odd-parity Hamming word that carries an extra overall parity bit. It has two independent streaming paths. The encode path takes a byte and returns its codeword. The decode path takes a received codeword and returns a byte with two flags. A single flipped bit anywhere in the word is repaired. Any two flipped bits are reported and left unrepaired.

Each path ends in a one-slot output register with a valid/ready handshake on both sides. A word moves across an interface on every rising clock edge where valid and ready are both high. An input is accepted whenever the output slot is empty, or is being emptied in the same cycle (`*_in_ready = !*_out_valid || *_out_ready`). While a result waits with ready low, the result stays unchanged and no new input is taken. A source that raises valid must hold its word until the transfer happens.

Top module: `secded_codec`

## Requirements
- R1: Codeword bit i is position i (0..12). Positions 0, 1, 2, 4 and 8 carry check bits. The byte fills positions 3, 5, 6, 7, 9, 10, 11 and 12 in that order, starting from data bit 7 and ending with data bit 0.
- R2: The check bit at position 2^k (k = 0..3) is set so that it has odd parity together with every position from 1 to 12 whose index has bit k set.
- R3: Position 0 is set so that all 13 bits together have odd parity. Byte 0x6B encodes to 0x1A65.
- R4: A received word with odd overall parity and all four checks passing returns its data bits, with both flags low.
- R5: A received word with even overall parity and a failing-check index s in 1..12 (check k failing adds 2^k) has bit s inverted before the data is extracted, and raises the single flag. Word 0x16D6 returns 0x1D with the single flag.
- R6: A received word with even overall parity and no failing check returns its data bits unchanged and raises the single flag.
- R7: A received word with odd overall parity and a nonzero failing-check index raises the double flag only. The data bits are returned exactly as received. The two flags are never high together.
- R8: A received word with even overall parity and a failing-check index of 13, 14 or 15 raises the double flag only and returns the received data bits.
- R9: On each path, a result is presented on the output one clock edge after its input was accepted. The input is ready exactly when the output slot is empty or is being taken in that cycle. Results leave in acceptance order.
- R10: While an output is valid and its ready is low, the output stays valid and its value does not change.
- R11: During and right after reset, both outputs are not valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_in_valid | input | 1 | Byte offered to the encoder |
| enc_in_ready | output | 1 | Encoder can take a byte this cycle |
| enc_in_data | input | 8 | Byte to encode |
| enc_out_valid | output | 1 | Codeword present |
| enc_out_ready | input | 1 | Downstream takes the codeword |
| enc_out_code | output | 13 | Codeword, bit i = position i |
| dec_in_valid | input | 1 | Codeword offered to the decoder |
| dec_in_ready | output | 1 | Decoder can take a codeword this cycle |
| dec_in_code | input | 13 | Received codeword, bit i = position i |
| dec_out_valid | output | 1 | Decoded result present |
| dec_out_ready | input | 1 | Downstream takes the result |
| dec_out_data | output | 8 | Corrected (or raw, on a double error) byte |
| dec_out_single | output | 1 | One bit was found in error and repaired |
| dec_out_double | output | 1 | Uncorrectable error detected |

## Verification
A codeword or decoded byte is due exactly one edge after the edge that accepted its input. The ready signals are due in the same cycle, because they follow the output slot and the downstream ready without a register. The bench drives each cycle half a period before the edge and samples 1 ns later. At that point it predicts the edge: it pushes the expected result for every accepted input, and it pops for every output taken. At the next sample it requires the output valid exactly when its queue is non-empty, with the queue head on the output. Cycles with ready low therefore check that the stalled output is held.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CHK_W  = 4;
  localparam int unsigned CODE_W = DATA_W + CHK_W + 1;
  localparam int unsigned IDX_W  = $clog2(CODE_W);
  localparam int unsigned DIDX_W = $clog2(DATA_W);
  localparam int unsigned SIDX_W = $clog2(CHK_W);

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [CHK_W-1:0]  synd_t;
  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [DIDX_W-1:0] didx_t;
  typedef logic [SIDX_W-1:0] sidx_t;

  typedef struct packed {
    data_t data;
    logic  single;
    logic  dbl;
  } dec_word_t;

  // position 0 and powers of two hold check bits
  function automatic bit is_chk_pos(int unsigned p);
    return (p & (p - 1)) == 0;
  endfunction

  // j-th data slot counted from the most significant data bit
  function automatic int unsigned data_pos(int unsigned j);
    int unsigned n;
    n = 0;
    for (int unsigned p = 1; p < CODE_W; p++) begin
      if (!is_chk_pos(p)) begin
        if (n == j) return p;
        n++;
      end
    end
    return 0;
  endfunction

  // positions 1..CODE_W-1 whose index has bit k set
  function automatic code_t cover_mask(int unsigned k);
    code_t m;
    m = '0;
    for (int unsigned p = 1; p < CODE_W; p++)
      if (((p >> k) & 1) != 0) m[idx_t'(p)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
(
  input  data_t data_i,
  output code_t code_o
);
  code_t word;

  always_comb begin
    word = '0;
    for (int unsigned j = 0; j < DATA_W; j++)
      word[idx_t'(data_pos(j))] = data_i[didx_t'(DATA_W - 1 - j)];
    // each check bit makes its covered group odd
    for (int unsigned k = 0; k < CHK_W; k++)
      word[idx_t'(1 << k)] = ~(^(word & cover_mask(k)));
    // overall bit makes the whole word odd
    word[0] = ~(^word);
  end

  assign code_o = word;
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_pkg::*;
(
  input  code_t code_i,
  output data_t data_o,
  output logic  single_o,
  output logic  dbl_o
);
  synd_t synd;
  logic  par_bad;
  logic  in_range;
  code_t fixed;

  always_comb begin
    for (int unsigned k = 0; k < CHK_W; k++)
      synd[sidx_t'(k)] = ~(^(code_i & cover_mask(k)));
    par_bad  = ~(^code_i);
    in_range = 32'(synd) < CODE_W;

    fixed = code_i;
    if (par_bad && (synd != '0) && in_range)
      fixed[idx_t'(synd)] = ~code_i[idx_t'(synd)];

    single_o = par_bad && in_range;
    dbl_o    = (!par_bad && (synd != '0)) || (par_bad && !in_range);

    for (int unsigned j = 0; j < DATA_W; j++)
      data_o[didx_t'(DATA_W - 1 - j)] = fixed[idx_t'(data_pos(j))];
  end
endmodule

// File: rtl/secded_pipe.sv
module secded_pipe #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (in_valid && in_ready) out_data <= in_data;
    end
  end

  // R10: a stalled result is held
  a_r10_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R9: an accepted word appears one edge later
  a_r9_accept_to_output: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && (out_data == $past(in_data)));
endmodule

// File: rtl/secded_codec.sv
module secded_codec
  import secded_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enc_in_valid,
  output logic        enc_in_ready,
  input  logic [7:0]  enc_in_data,
  output logic        enc_out_valid,
  input  logic        enc_out_ready,
  output logic [12:0] enc_out_code,
  input  logic        dec_in_valid,
  output logic        dec_in_ready,
  input  logic [12:0] dec_in_code,
  output logic        dec_out_valid,
  input  logic        dec_out_ready,
  output logic [7:0]  dec_out_data,
  output logic        dec_out_single,
  output logic        dec_out_double
);
  code_t     enc_code;
  dec_word_t dec_word;
  dec_word_t dec_held;

  secded_enc u_enc (
    .data_i (enc_in_data),
    .code_o (enc_code)
  );

  secded_pipe #(.W(CODE_W)) u_enc_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (enc_in_valid),
    .in_ready  (enc_in_ready),
    .in_data   (enc_code),
    .out_valid (enc_out_valid),
    .out_ready (enc_out_ready),
    .out_data  (enc_out_code)
  );

  secded_dec u_dec (
    .code_i   (dec_in_code),
    .data_o   (dec_word.data),
    .single_o (dec_word.single),
    .dbl_o    (dec_word.dbl)
  );

  secded_pipe #(.W($bits(dec_word_t))) u_dec_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (dec_in_valid),
    .in_ready  (dec_in_ready),
    .in_data   (dec_word),
    .out_valid (dec_out_valid),
    .out_ready (dec_out_ready),
    .out_data  (dec_held)
  );

  assign dec_out_data   = dec_held.data;
  assign dec_out_single = dec_held.single;
  assign dec_out_double = dec_held.dbl;

  // R3: every presented codeword has odd overall parity
  a_r3_code_odd: assert property (@(posedge clk) disable iff (!rst_n)
    enc_out_valid |-> (^enc_out_code));

  // R7: the two flags never appear together
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    dec_out_valid |-> !(dec_out_single && dec_out_double));
endmodule

// File: tb/sim_secded_codec.sv
`timescale 1ns/1ps
module sim_secded_codec;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enc_in_valid, enc_in_ready, enc_out_valid, enc_out_ready;
  logic [7:0]  enc_in_data;
  logic [12:0] enc_out_code;
  logic        dec_in_valid, dec_in_ready, dec_out_valid, dec_out_ready;
  logic [12:0] dec_in_code;
  logic [7:0]  dec_out_data;
  logic        dec_out_single, dec_out_double;

  always #2.5 clk = ~clk;

  secded_codec u0 (.*);

  typedef struct {
    logic [12:0] code;
    logic [7:0]  d;
    logic        s;
    logic        x;
    string       tag;
  } dvec_t;

  int checks = 0;
  int fails  = 0;
  logic [12:0] enc_q[$];
  string       enc_tag_q[$];
  dvec_t       dec_q[$];
  logic [7:0]  enc_dir[$];
  dvec_t       dec_dir[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // behavioural model of the code layout (R1, R2, R3)
  function automatic logic [12:0] ref_encode(input logic [7:0] d);
    logic [12:0] c;
    int n, ones;
    c = '0;
    n = 7;
    for (int p = 1; p < 13; p++)
      if (p != 1 && p != 2 && p != 4 && p != 8) begin
        c[p] = d[n];
        n--;
      end
    for (int k = 0; k < 4; k++) begin
      ones = 0;
      for (int p = 1; p < 13; p++)
        if (((p >> k) & 1) == 1 && p != (1 << k) && c[p]) ones++;
      c[1 << k] = (ones % 2 == 0);
    end
    ones = 0;
    for (int p = 1; p < 13; p++) if (c[p]) ones++;
    c[0] = (ones % 2 == 0);
    return c;
  endfunction

  function automatic logic [7:0] ref_extract(input logic [12:0] c);
    logic [7:0] d;
    int n;
    n = 7;
    for (int p = 1; p < 13; p++)
      if (p != 1 && p != 2 && p != 4 && p != 8) begin
        d[n] = c[p];
        n--;
      end
    return d;
  endfunction

  function automatic dvec_t make_dec(input int cls);
    dvec_t v;
    logic [7:0] d;
    int p1, p2;
    d = 8'($urandom);
    v.code = ref_encode(d);
    v.d = d; v.s = 1'b0; v.x = 1'b0; v.tag = "R4";
    case (cls)
      1: begin p1 = 1 + int'($urandom % 12); v.code[p1] = ~v.code[p1]; v.s = 1'b1; v.tag = "R5"; end
      2: begin v.code[0] = ~v.code[0]; v.s = 1'b1; v.tag = "R6"; end
      3: begin
        p1 = int'($urandom % 13);
        p2 = (p1 + 1 + int'($urandom % 12)) % 13;
        v.code[p1] = ~v.code[p1];
        v.code[p2] = ~v.code[p2];
        v.d = ref_extract(v.code); v.x = 1'b1; v.tag = "R7";
      end
      4: begin
        case ($urandom % 3)
          0: v.code = v.code ^ 13'h0112;  // positions 1,4,8 -> index 13
          1: v.code = v.code ^ 13'h0114;  // positions 2,4,8 -> index 14
          default: v.code = v.code ^ 13'h0124; // positions 2,5,8 -> index 15
        endcase
        v.d = ref_extract(v.code); v.x = 1'b1; v.tag = "R8";
      end
      default: ;
    endcase
    return v;
  endfunction

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit enc_taken, dec_taken, enc_stall, dec_stall;
    dvec_t v, cur_dec;
    logic [7:0] cur_enc;
    enc_taken = 0; dec_taken = 0; enc_stall = 0; dec_stall = 0;
    rst_n = 1'b0;
    enc_in_valid = 0; enc_in_data = '0; enc_out_ready = 0;
    dec_in_valid = 0; dec_in_code = '0; dec_out_ready = 0;

    // directed vectors
    enc_dir.push_back(8'h6B);  // R3 example
    enc_dir.push_back(8'h00);
    enc_dir.push_back(8'hFF);
    v.code = 13'h16D6; v.d = 8'h1D; v.s = 1; v.x = 0; v.tag = "R5"; dec_dir.push_back(v);
    v.code = ref_encode(8'hA5) ^ 13'h0001; v.d = 8'hA5; v.s = 1; v.x = 0; v.tag = "R6"; dec_dir.push_back(v);
    v.code = ref_encode(8'h3C) ^ 13'h0112; v.d = ref_extract(v.code); v.s = 0; v.x = 1; v.tag = "R8"; dec_dir.push_back(v);
    v.code = ref_encode(8'h81) ^ 13'h0041; v.d = ref_extract(v.code); v.s = 0; v.x = 1; v.tag = "R7"; dec_dir.push_back(v);

    repeat (3) @(negedge clk);
    // R11: nothing valid in reset
    check(!enc_out_valid && !dec_out_valid, "R11", "out_valid in reset",
          {14'd0, enc_out_valid, dec_out_valid}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!enc_out_valid && !dec_out_valid, "R11", "out_valid after reset",
          {14'd0, enc_out_valid, dec_out_valid}, 16'd0);

    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      // drive: hold an offered word until it is taken
      if (!enc_in_valid || enc_taken) begin
        enc_taken = 0;
        if (cyc < 3800 && ($urandom % 100) < 70) begin
          enc_in_valid = 1;
          enc_in_data = (enc_dir.size() != 0) ? enc_dir.pop_front() : 8'($urandom);
        end else enc_in_valid = 0;
      end
      if (!dec_in_valid || dec_taken) begin
        dec_taken = 0;
        if (cyc < 3800 && ($urandom % 100) < 70) begin
          cur_dec = (dec_dir.size() != 0) ? dec_dir.pop_front() : make_dec(int'($urandom % 5));
          dec_in_valid = 1;
          dec_in_code = cur_dec.code;
        end else dec_in_valid = 0;
      end
      if (cyc < 800 || cyc >= 3000) begin
        enc_out_ready = 1; dec_out_ready = 1;
      end else begin
        enc_out_ready = ($urandom % 2) == 0;
        dec_out_ready = ($urandom % 3) == 0;
      end
      #1;
      // encode path
      check(enc_out_valid == (enc_q.size() != 0), enc_stall ? "R10" : "R9", "enc_out_valid",
            {15'd0, enc_out_valid}, {15'd0, enc_q.size() != 0});
      check(enc_in_ready == (!enc_out_valid || enc_out_ready), "R9", "enc_in_ready",
            {15'd0, enc_in_ready}, {15'd0, !enc_out_valid || enc_out_ready});
      if (enc_out_valid && enc_q.size() != 0)
        check(enc_out_code == enc_q[0], enc_stall ? "R10" : enc_tag_q[0], "enc_out_code",
              {3'd0, enc_out_code}, {3'd0, enc_q[0]});
      enc_stall = enc_out_valid && !enc_out_ready;
      if (enc_out_valid && enc_out_ready && enc_q.size() != 0) begin
        void'(enc_q.pop_front()); void'(enc_tag_q.pop_front());
      end
      if (enc_in_valid && enc_in_ready) begin
        cur_enc = enc_in_data;
        enc_q.push_back(ref_encode(cur_enc));
        enc_tag_q.push_back(cur_enc == 8'h6B ? "R3" : "R1,R2,R3");
        enc_taken = 1;
      end
      // decode path
      check(dec_out_valid == (dec_q.size() != 0), dec_stall ? "R10" : "R9", "dec_out_valid",
            {15'd0, dec_out_valid}, {15'd0, dec_q.size() != 0});
      check(dec_in_ready == (!dec_out_valid || dec_out_ready), "R9", "dec_in_ready",
            {15'd0, dec_in_ready}, {15'd0, !dec_out_valid || dec_out_ready});
      if (dec_out_valid && dec_q.size() != 0)
        check({dec_out_data, dec_out_single, dec_out_double} ==
              {dec_q[0].d, dec_q[0].s, dec_q[0].x},
              dec_stall ? "R10" : dec_q[0].tag, "dec data,single,double",
              {6'd0, dec_out_data, dec_out_single, dec_out_double},
              {6'd0, dec_q[0].d, dec_q[0].s, dec_q[0].x});
      dec_stall = dec_out_valid && !dec_out_ready;
      if (dec_out_valid && dec_out_ready && dec_q.size() != 0) void'(dec_q.pop_front());
      if (dec_in_valid && dec_in_ready) begin
        dec_q.push_back(cur_dec);
        dec_taken = 1;
      end
    end

    check(enc_q.size() == 0 && dec_q.size() == 0, "R9", "queues drained",
          16'(enc_q.size() + dec_q.size()), 16'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule